// File: doc/BRIEF.md
# Prioritized Restart Interrupt Controller

This block decides which pending interrupt a processor core takes at an instruction boundary. It has five sources. One is a non-maskable source. Three are vectored restart sources, each with its own mask bit. The last is a general request whose handler instruction comes from an external device during an acknowledge cycle. The core pulses `sample_i` in the next-to-last clock of every instruction. On that edge the block selects at most one source by fixed priority and reports it for one clock: a take pulse, the fixed 16-bit handler address, and, for the general request, a flag that asks the core to run an acknowledge cycle. That cycle has the timing of a read. The stack push and the fetch of the supplied instruction belong to the core.

Software controls the block through three commands. The enable strobe and the disable strobe set and clear a global enable. A mask command loads the three restart masks and can also discard a latched edge on the highest restart source. Any accepted interrupt clears the global enable. A separate combinational helper turns a 3-bit restart number into its handler address, so the core can decode restart opcodes.

There are three state machines. The global enable machine has states EN_OFF and EN_ON. Its transitions are: OFF to ON on the enable strobe; ON to OFF on the disable strobe or on any accept. The non-maskable edge machine has states NMI_LOW, NMI_PEND and NMI_USED. Its transitions are: LOW to PEND when the input rises without a sample; LOW or PEND to USED when the request is taken; PEND to LOW when the input drops before it is taken; USED to LOW when the input drops. The output register holds the source taken at the last sample edge: SRC_NONE, SRC_NMI, SRC_HI, SRC_MID, SRC_LO or SRC_GEN. It moves to the winner on a sample edge and back to SRC_NONE on every other edge.

Top module: `irq_prio_ctl`

## Requirements
- R1: After reset `take_o` and `ack_req_o` are 0 and `vec_o` is 0. The global enable is off. All three restart masks are set, so the restart sources are masked. The edge latch of the highest restart source is empty.
- R2: Requests are examined only at a rising clock edge where `sample_i` is 1. `take_o`, `vec_o` and `ack_req_o` are registered and show the result for exactly the one clock after that edge. In every other clock `take_o` is 0 and `vec_o` is 0.
- R3: When several sources are eligible at one sample edge, exactly one is taken. The order, highest first, is: non-maskable, restart high, restart mid, restart low, general.
- R4: The handler addresses on `vec_o` are 0x0024 for the non-maskable source, 0x003C for restart high, 0x0034 for restart mid and 0x002C for restart low.
- R5: The non-maskable source is taken whatever the masks and the global enable are. It needs a rising edge on `nmi_i` that is still high at the sample edge. One high pulse is taken only once. A pulse that falls before any sample edge is lost. After reset the input counts as low.
- R6: `en_set_i` turns the global enable on and `en_clr_i` turns it off; if both are high, the clear wins. Every accept, including a non-maskable one, turns it off at the same edge. A change applies from the next sample edge on. While the enable is off, no maskable source is taken.
- R7: A clock with `mask_wr_i` high loads `mask_val_i`. Bit 0 masks restart low, bit 1 masks restart mid and bit 2 masks restart high; a bit value of 1 means masked. A masked source is never taken.
- R8: A rising edge on `rs_hi_i` latches a pending request. The request stays pending until it is taken, or until a clock where both `mask_wr_i` and `mask_clr75_i` are high. A masked pending request is kept and is taken once it is unmasked. A new edge in the same clock as a clear leaves the request pending.
- R9: `rs_mid_i`, `rs_lo_i` and `gen_req_i` are level-sensitive: each is taken only if it is high at the sample edge.
- R10: When the general request is taken, `ack_req_o` is 1 and `vec_o` is 0 during the take clock. For all other sources `ack_req_o` is 0.
- R11: `rs_addr_o` equals `rs_num_i` times 8 and depends only on `rs_num_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_i | input | 1 | Next-to-last clock of an instruction |
| nmi_i | input | 1 | Non-maskable request |
| rs_hi_i | input | 1 | Highest restart request, edge-latched |
| rs_mid_i | input | 1 | Middle restart request, level |
| rs_lo_i | input | 1 | Lowest restart request, level |
| gen_req_i | input | 1 | General request needing acknowledge, level |
| en_set_i | input | 1 | Global enable on strobe |
| en_clr_i | input | 1 | Global enable off strobe |
| mask_wr_i | input | 1 | Mask command strobe |
| mask_val_i | input | 3 | New masks: bit0 low, bit1 mid, bit2 high; 1 = masked |
| mask_clr75_i | input | 1 | With mask_wr_i, clears latched high request |
| rs_num_i | input | 3 | Restart number for the address helper |
| rs_addr_o | output | 16 | Restart number times 8 |
| take_o | output | 1 | One-clock accept pulse |
| vec_o | output | 16 | Handler address during take_o, else 0 |
| ack_req_o | output | 1 | Acknowledge cycle needed (general request taken) |

## Verification
Directed sequences first raise several sources together and then drop the winner each time, which checks the priority order and every vector. A general request offered with the enable off, and again with it on, separates the effect of the global enable from the masks. Short non-maskable pulses are placed before a sample, across a sample and held over two samples; these tell edge detection apart from level sensing and from consumption. A high-restart pulse that is masked, later unmasked, or cleared by the mask command checks the latch apart from the level sources. A long random run then drives every input, and a behavioural model compares the outputs on every clock.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int VEC_W = 16;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_NMI,
        SRC_HI,
        SRC_MID,
        SRC_LO,
        SRC_GEN
    } src_e;

    typedef enum logic [1:0] {
        NMI_LOW,
        NMI_PEND,
        NMI_USED
    } nmi_st_e;

    typedef enum logic {
        EN_OFF,
        EN_ON
    } en_st_e;

    localparam logic [VEC_W-1:0] VEC_NMI = 16'h0024;
    localparam logic [VEC_W-1:0] VEC_HI  = 16'h003C;
    localparam logic [VEC_W-1:0] VEC_MID = 16'h0034;
    localparam logic [VEC_W-1:0] VEC_LO  = 16'h002C;

    function automatic logic [VEC_W-1:0] src_vec(input src_e s);
        logic [VEC_W-1:0] v;
        unique case (s)
            SRC_NMI:  v = VEC_NMI;
            SRC_HI:   v = VEC_HI;
            SRC_MID:  v = VEC_MID;
            SRC_LO:   v = VEC_LO;
            SRC_GEN:  v = '0;
            SRC_NONE: v = '0;
            default:  v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/irq_nmi_fsm.sv
module irq_nmi_fsm
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_i,
    input  logic take_i,
    output logic pend_o
);

    nmi_st_e st_q;
    nmi_st_e st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            NMI_LOW: begin
                if (nmi_i && take_i)      st_d = NMI_USED;
                else if (nmi_i)           st_d = NMI_PEND;
            end
            NMI_PEND: begin
                if (take_i)               st_d = NMI_USED;
                else if (!nmi_i)          st_d = NMI_LOW;
            end
            NMI_USED: begin
                if (!nmi_i)               st_d = NMI_LOW;
            end
            default:                      st_d = NMI_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= NMI_LOW;
        else        st_q <= st_d;
    end

    always_comb begin
        pend_o = nmi_i && (st_q != NMI_USED);
    end

    // R5
    nmi_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> (st_q == NMI_USED));

    // R5
    nmi_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && nmi_i) |=> !pend_o);

endmodule

// File: rtl/irq_hi_latch.sv
module irq_hi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic take_i,
    input  logic clr_i,
    output logic pend_o
);

    logic lvl_q;
    logic pend_q;
    logic rise;

    always_comb begin
        rise = lvl_i && !lvl_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            lvl_q  <= lvl_i;
            pend_q <= rise || (pend_q && !take_i && !clr_i);
        end
    end

    always_comb begin
        pend_o = pend_q;
    end

    // R8
    hi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((take_i || clr_i) && !lvl_i) |=> !pend_o);

    // R8
    hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !take_i && !clr_i) |=> pend_o);

endmodule

// File: rtl/irq_enable_fsm.sv
module irq_enable_fsm
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic acc_i,
    output logic en_o
);

    en_st_e st_q;
    en_st_e st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            EN_OFF: if (set_i && !clr_i && !acc_i) st_d = EN_ON;
            EN_ON:  if (clr_i || acc_i)            st_d = EN_OFF;
            default:                               st_d = EN_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= EN_OFF;
        else        st_q <= st_d;
    end

    always_comb begin
        en_o = (st_q == EN_ON);
    end

    // R6
    en_acc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_i |=> !en_o);

    // R6
    en_set_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_i && !acc_i) |=> en_o);

endmodule

// File: rtl/irq_prio_ctl.sv
module irq_prio_ctl
    import irq_pkg::*;
#(
    parameter int NUM_W = 3,
    parameter int SLOT_SH = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_i,
    input  logic                 nmi_i,
    input  logic                 rs_hi_i,
    input  logic                 rs_mid_i,
    input  logic                 rs_lo_i,
    input  logic                 gen_req_i,
    input  logic                 en_set_i,
    input  logic                 en_clr_i,
    input  logic                 mask_wr_i,
    input  logic [2:0]           mask_val_i,
    input  logic                 mask_clr75_i,
    input  logic [NUM_W-1:0]     rs_num_i,
    output logic [VEC_W-1:0]     rs_addr_o,
    output logic                 take_o,
    output logic [VEC_W-1:0]     vec_o,
    output logic                 ack_req_o
);

    localparam int PAD_W = VEC_W - NUM_W - SLOT_SH;
    localparam int M_LO  = 0;
    localparam int M_MID = 1;
    localparam int M_HI  = 2;

    logic [2:0] mask_q;
    logic       nmi_pend;
    logic       hi_pend;
    logic       en;
    src_e       sel_d;
    src_e       src_q;
    logic       acc;

    // restart number to handler address helper
    always_comb begin
        rs_addr_o = {{PAD_W{1'b0}}, rs_num_i, {SLOT_SH{1'b0}}};
    end

    // mask register
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= 3'b111;
        else if (mask_wr_i) mask_q <= mask_val_i;
    end

    // priority selection at the sample edge
    always_comb begin
        sel_d = SRC_NONE;
        if (sample_i) begin
            if (nmi_pend)                              sel_d = SRC_NMI;
            else if (en && hi_pend && !mask_q[M_HI])   sel_d = SRC_HI;
            else if (en && rs_mid_i && !mask_q[M_MID]) sel_d = SRC_MID;
            else if (en && rs_lo_i && !mask_q[M_LO])   sel_d = SRC_LO;
            else if (en && gen_req_i)                  sel_d = SRC_GEN;
        end
        acc = (sel_d != SRC_NONE);
    end

    irq_nmi_fsm u_nmi (
        .clk    (clk),
        .rst_n  (rst_n),
        .nmi_i  (nmi_i),
        .take_i (sel_d == SRC_NMI),
        .pend_o (nmi_pend)
    );

    irq_hi_latch u_hi (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (rs_hi_i),
        .take_i (sel_d == SRC_HI),
        .clr_i  (mask_wr_i && mask_clr75_i),
        .pend_o (hi_pend)
    );

    irq_enable_fsm u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (en_set_i),
        .clr_i (en_clr_i),
        .acc_i (acc),
        .en_o  (en)
    );

    // output state register
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= SRC_NONE;
        else        src_q <= sel_d;
    end

    // output decode
    always_comb begin
        take_o    = 1'b0;
        ack_req_o = 1'b0;
        vec_o     = '0;
        unique case (src_q)
            SRC_NONE: ;
            SRC_GEN: begin
                take_o    = 1'b1;
                ack_req_o = 1'b1;
            end
            SRC_NMI, SRC_HI, SRC_MID, SRC_LO: begin
                take_o = 1'b1;
                vec_o  = src_vec(src_q);
            end
            default: ;
        endcase
    end

    // R2
    take_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(sample_i));

    // R2
    take_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_i |=> !take_o);

    // R5
    nmi_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_i && nmi_pend) |=> (vec_o == VEC_NMI));

    // R6
    en_off_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_i && !nmi_pend && !en) |=> !take_o);

    // R10
    ack_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req_o |-> (take_o && (vec_o == '0)));

endmodule

// File: tb/irq_prio_ctl_tb_top.sv
`timescale 1ns/1ps
module irq_prio_ctl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_i = 1'b0;
    logic        nmi_i = 1'b0;
    logic        rs_hi_i = 1'b0;
    logic        rs_mid_i = 1'b0;
    logic        rs_lo_i = 1'b0;
    logic        gen_req_i = 1'b0;
    logic        en_set_i = 1'b0;
    logic        en_clr_i = 1'b0;
    logic        mask_wr_i = 1'b0;
    logic [2:0]  mask_val_i = 3'b111;
    logic        mask_clr75_i = 1'b0;
    logic [2:0]  rs_num_i = 3'd0;
    logic [15:0] rs_addr_o;
    logic        take_o;
    logic [15:0] vec_o;
    logic        ack_req_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state: src codes 0 none,1 nmi,2 hi,3 mid,4 lo,5 gen
    int m_nmi_state = 0;   // 0 low-seen, 1 pending, 2 used
    bit m_hi_prev = 0;
    bit m_hi_pend = 0;
    bit [2:0] m_mask = 3'b111;
    bit m_en = 0;
    int m_src = 0;

    always #2.5 clk = ~clk;

    irq_prio_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .nmi_i(nmi_i),
        .rs_hi_i(rs_hi_i), .rs_mid_i(rs_mid_i), .rs_lo_i(rs_lo_i),
        .gen_req_i(gen_req_i), .en_set_i(en_set_i), .en_clr_i(en_clr_i),
        .mask_wr_i(mask_wr_i), .mask_val_i(mask_val_i),
        .mask_clr75_i(mask_clr75_i), .rs_num_i(rs_num_i),
        .rs_addr_o(rs_addr_o), .take_o(take_o), .vec_o(vec_o),
        .ack_req_o(ack_req_o)
    );

    function automatic logic [15:0] exp_vec(int s);
        case (s)
            1: return 16'h0024;
            2: return 16'h003C;
            3: return 16'h0034;
            4: return 16'h002C;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic string tag_of(int s);
        case (s)
            1: return "R5";
            2: return "R8";
            3: return "R9";
            4: return "R9";
            5: return "R10";
            default: return "R2";
        endcase
    endfunction

    task automatic model_step();
        int sel = 0;
        bit nmi_p;
        if (!rst_n) begin
            m_nmi_state = 0; m_hi_prev = 0; m_hi_pend = 0;
            m_mask = 3'b111; m_en = 0; m_src = 0;
            return;
        end
        nmi_p = nmi_i && (m_nmi_state != 2);
        if (sample_i) begin
            if (nmi_p) sel = 1;
            else if (m_en && m_hi_pend && !m_mask[2]) sel = 2;
            else if (m_en && rs_mid_i && !m_mask[1]) sel = 3;
            else if (m_en && rs_lo_i && !m_mask[0]) sel = 4;
            else if (m_en && gen_req_i) sel = 5;
        end
        if (sel == 1) m_nmi_state = 2;
        else if (!nmi_i) m_nmi_state = 0;
        else if (m_nmi_state == 0) m_nmi_state = 1;
        m_hi_pend = (rs_hi_i && !m_hi_prev) ||
                    (m_hi_pend && sel != 2 && !(mask_wr_i && mask_clr75_i));
        m_hi_prev = rs_hi_i;
        if (mask_wr_i) m_mask = mask_val_i;
        if (sel != 0 || en_clr_i) m_en = 0;
        else if (en_set_i) m_en = 1;
        m_src = sel;
    endtask

    task automatic compare_model();
        bit ok;
        ok = (take_o == (m_src != 0)) && (vec_o == exp_vec(m_src)) &&
             (ack_req_o == (m_src == 5));
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s model: take=%0b vec=%h ack=%0b expected take=%0b vec=%h ack=%0b",
                     tag_of(m_src), take_o, vec_o, ack_req_o, m_src != 0,
                     exp_vec(m_src), m_src == 5);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_model();
    endtask

    task automatic chk(string tag, bit t, logic [15:0] v, bit a);
        checks++;
        if (take_o !== t || vec_o !== v || ack_req_o !== a) begin
            errors++;
            $display("FAIL %s: take=%0b vec=%h ack=%0b expected take=%0b vec=%h ack=%0b",
                     tag, take_o, vec_o, ack_req_o, t, v, a);
        end
    endtask

    task automatic smp();
        sample_i = 1; cyc(); sample_i = 0;
    endtask

    task automatic ena();
        en_set_i = 1; cyc(); en_set_i = 0;
    endtask

    task automatic mwr(bit [2:0] m, bit c);
        mask_wr_i = 1; mask_val_i = m; mask_clr75_i = c; cyc();
        mask_wr_i = 0; mask_clr75_i = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        chk("R1 reset outputs", 0, 16'h0000, 0);

        // R6: enable off blocks general request
        gen_req_i = 1; smp();
        chk("R6 enable off", 0, 16'h0000, 0);
        // R10: general taken with enable on
        ena(); smp();
        chk("R10 general", 1, 16'h0000, 1);
        cyc();
        chk("R2 single pulse", 0, 16'h0000, 0);
        // R6: accept cleared enable
        smp();
        chk("R6 cleared by accept", 0, 16'h0000, 0);
        // R1/R7: restarts masked from reset
        gen_req_i = 0; rs_lo_i = 1; rs_mid_i = 1; ena(); smp();
        chk("R7 masked after reset", 0, 16'h0000, 0);
        // R3 ordering among levels
        mwr(3'b000, 0); gen_req_i = 1; smp();
        chk("R3 mid over lo/gen", 1, 16'h0034, 0);
        rs_mid_i = 0; ena(); smp();
        chk("R4 lo vector", 1, 16'h002C, 0);
        rs_lo_i = 0; ena(); smp();
        chk("R3 gen last", 1, 16'h0000, 1);
        gen_req_i = 0;
        // R7: mask only mid
        rs_mid_i = 1; rs_lo_i = 1; mwr(3'b010, 0); ena(); smp();
        chk("R7 mid masked", 1, 16'h002C, 0);
        rs_mid_i = 0; rs_lo_i = 0;
        // R8: high latch from a short pulse
        rs_hi_i = 1; cyc(); rs_hi_i = 0; cyc();
        ena(); smp();
        chk("R8 latched edge", 1, 16'h003C, 0);
        // R8: masked pending kept, taken after unmask
        mwr(3'b100, 0);
        rs_hi_i = 1; cyc(); rs_hi_i = 0;
        ena(); smp();
        chk("R8 masked hold", 0, 16'h0000, 0);
        mwr(3'b000, 0); smp();
        chk("R8 unmasked take", 1, 16'h003C, 0);
        // R8: clear by mask command
        rs_hi_i = 1; cyc(); rs_hi_i = 0;
        mwr(3'b000, 1); ena(); smp();
        chk("R8 cleared", 0, 16'h0000, 0);
        // R9: level gone before sample
        rs_mid_i = 1; cyc(); rs_mid_i = 0; smp();
        chk("R9 level dropped", 0, 16'h0000, 0);
        // R5: nmi ignores enable and masks
        en_clr_i = 1; cyc(); en_clr_i = 0;
        mwr(3'b111, 0);
        nmi_i = 1; rs_lo_i = 1; cyc(); smp();
        chk("R5 nmi bypass", 1, 16'h0024, 0);
        smp();
        chk("R5 held pulse once", 0, 16'h0000, 0);
        nmi_i = 0; cyc();
        nmi_i = 1; cyc(); nmi_i = 0; smp();
        chk("R5 pulse lost", 0, 16'h0000, 0);
        // R3: nmi beats everything
        mwr(3'b000, 0); rs_hi_i = 1; rs_mid_i = 1; gen_req_i = 1; ena();
        nmi_i = 1; smp();
        chk("R3 nmi first", 1, 16'h0024, 0);
        nmi_i = 0; ena(); smp();
        chk("R3 hi second", 1, 16'h003C, 0);
        rs_hi_i = 0; rs_mid_i = 0; rs_lo_i = 0; gen_req_i = 0; cyc();
        // R11 helper
        for (int n = 0; n < 8; n++) begin
            rs_num_i = 3'(n); #1;
            checks++;
            if (rs_addr_o !== 16'(n * 8)) begin
                errors++;
                $display("FAIL R11: addr=%h expected %h", rs_addr_o, 16'(n * 8));
            end
        end
        // random run compared to model every clock
        for (int i = 0; i < 4000; i++) begin
            sample_i   = ($urandom_range(3) == 0);
            en_set_i   = ($urandom_range(5) == 0);
            en_clr_i   = ($urandom_range(15) == 0);
            mask_wr_i  = ($urandom_range(15) == 0);
            mask_val_i = 3'($urandom_range(7));
            mask_clr75_i = ($urandom_range(1) == 0);
            if ($urandom_range(9) == 0) nmi_i = ~nmi_i;
            if ($urandom_range(5) == 0) rs_hi_i = ~rs_hi_i;
            rs_mid_i  = ($urandom_range(3) == 0);
            rs_lo_i   = ($urandom_range(2) == 0);
            gen_req_i = ($urandom_range(1) == 0);
            if (i == 2000) rst_n = 0;
            if (i == 2003) rst_n = 1;
            cyc();
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule